// File: doc/BRIEF.md
# Split-Mode Dual 8-bit Timer

This block holds two timer/counters that share one prescaler. The first timer can be split into two independent 8-bit counters. Its low byte works as a timer or as an event counter, and the first timer's run bit, gate bit and an external gate pin control it. Its high byte counts only prescaled clock ticks. While the first timer is split, the high byte takes over the second timer's run bit and overflow flag.

The second timer is a 16-bit up counter of prescaled ticks. When it is put into split mode itself, it holds its value. While the first timer is split, the second timer still counts whenever it is outside split mode, but it ignores its own run bit and can no longer touch its overflow flag. Software can therefore start and stop it only by moving it out of split mode and back into it.

Both overflow flags are sticky. Each has a clear input for software, and a flag being set in the same cycle as a clear takes priority over the clear.

Top module: `split_timer_pair`

## Requirements
- R1: While `rst_n` is low, all counter outputs and both flags are 0.
- R2: The prescaler produces one tick every 12 clocks when `fast_sel` is 0 and every 4 clocks when `fast_sel` is 1. Over any 48-clock window, a counter that is enabled on ticks therefore advances by 4 or by 12.
- R3: The first timer counts only while `run0` is 1 and either `gate0` is 0 or `gate_pin0` is 1. Otherwise its bytes hold their values.
- R4: With `cnt_sel0` = 1, the first timer counts falling edges of `event_pin` instead of ticks. The pin is sampled through two flip-flops, and each 1-to-0 change of the sampled value gives exactly one count.
- R5: With `mode0` = 2'b11 (split mode), the low byte wraps from FFh to 00h on its own and sets `ovf0` as it wraps.
- R6: In split mode, the high byte `cnt0_hi` advances on every tick while `run1` is 1, regardless of `run0`, `gate0`, `cnt_sel0` and the event pin.
- R7: In split mode, a wrap of the high byte from FFh to 00h sets `ovf1` and leaves `ovf0` unchanged.
- R8: While `mode1` = 2'b11, `cnt1` holds its value.
- R9: While `mode0` = 2'b11 and `mode1` is not 2'b11, the second timer counts ticks with `run1` ignored, and it never sets `ovf1`.
- R10: When `mode0` is not 2'b11, the first timer's two bytes form one 16-bit counter: a low-byte wrap carries into `cnt0_hi`, and `ovf0` is set only when the 16-bit value wraps from FFFFh to 0000h.
- R11: A 1 on `ovf0_clr` or `ovf1_clr` clears the matching flag on the next clock edge, unless the flag is being set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_sel | input | 1 | Prescale select: 0 divides by 12, 1 divides by 4 |
| event_pin | input | 1 | External event input, counted on falling edges |
| gate_pin0 | input | 1 | External gate for the first timer |
| gate_pin1 | input | 1 | External gate for the second timer |
| mode0 | input | 2 | First timer mode; 2'b11 selects split mode |
| mode1 | input | 2 | Second timer mode; 2'b11 freezes it |
| cnt_sel0 | input | 1 | First timer source: 0 ticks, 1 event pin |
| gate0 | input | 1 | First timer gate enable |
| run0 | input | 1 | First timer run bit |
| gate1 | input | 1 | Second timer gate enable |
| run1 | input | 1 | Second timer run bit (used by the high byte in split mode) |
| ovf0_clr | input | 1 | Clears `ovf0` |
| ovf1_clr | input | 1 | Clears `ovf1` |
| cnt0_lo | output | 8 | First timer low byte |
| cnt0_hi | output | 8 | First timer high byte |
| cnt1 | output | 16 | Second timer count |
| ovf0 | output | 1 | First timer overflow flag |
| ovf1 | output | 1 | Second timer overflow flag |

## Verification
The hardest situation to reach is the one where the second timer has lost its own controls. The first timer has to be split, the high byte has to be driven to its wrap by `run1`, and at the same time the second timer has to be moved into and out of its own split mode with `run1` low. Only then does it show that the freeze, the ignored run bit and the flag routing are independent of one another. The stimulus reaches this state by parking the first timer in split mode at the fast prescale. It runs the high byte through a full wrap, then toggles `mode1` while keeping `run1` at 0. Sticky-flag clears are pulsed at random throughout, and a cycle-accurate behavioural model tracks every output on every clock.

// File: rtl/split_timer_pair.sv
module split_timer_pair #(
  parameter int BYTE_W   = 8,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fast_sel,
  input  logic                event_pin,
  input  logic                gate_pin0,
  input  logic                gate_pin1,
  input  logic [1:0]          mode0,
  input  logic [1:0]          mode1,
  input  logic                cnt_sel0,
  input  logic                gate0,
  input  logic                run0,
  input  logic                gate1,
  input  logic                run1,
  input  logic                ovf0_clr,
  input  logic                ovf1_clr,
  output logic [BYTE_W-1:0]   cnt0_lo,
  output logic [BYTE_W-1:0]   cnt0_hi,
  output logic [2*BYTE_W-1:0] cnt1,
  output logic                ovf0,
  output logic                ovf1
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
  localparam logic [1:0] SPLIT = 2'b11;

  logic [PW-1:0] pre;
  logic          tick;
  logic          smp_a, smp_b, fall;
  logic          split0, frz1, en0, inc0, inc_hi, en1, inc1;
  logic          lo_top, hi_top, t1_top;
  logic          set0, set1;

  assign tick   = pre >= (fast_sel ? LIM_FAST : LIM_SLOW);
  assign fall   = smp_b & ~smp_a;
  assign split0 = (mode0 == SPLIT);
  assign frz1   = (mode1 == SPLIT);
  assign en0    = run0 & (~gate0 | gate_pin0);
  assign inc0   = en0 & (cnt_sel0 ? fall : tick);
  assign inc_hi = split0 & run1 & tick;
  assign en1    = ~frz1 & (split0 | run1) & (~gate1 | gate_pin1);
  assign inc1   = en1 & tick;
  assign lo_top = &cnt0_lo;
  assign hi_top = &cnt0_hi;
  assign t1_top = &cnt1;
  assign set0   = inc0 & lo_top & (split0 | hi_top);
  assign set1   = (inc_hi & hi_top) | (~split0 & inc1 & t1_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      smp_a <= 1'b0;
      smp_b <= 1'b0;
    end else begin
      pre   <= tick ? '0 : pre + 1'b1;
      smp_a <= event_pin;
      smp_b <= smp_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0_lo <= '0;
      cnt0_hi <= '0;
    end else if (split0) begin
      if (inc0)   cnt0_lo <= cnt0_lo + 1'b1;
      if (inc_hi) cnt0_hi <= cnt0_hi + 1'b1;
    end else if (inc0) begin
      cnt0_lo <= cnt0_lo + 1'b1;
      if (lo_top) cnt0_hi <= cnt0_hi + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt1 <= '0;
    else if (inc1) cnt1 <= cnt1 + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf0 <= 1'b0;
      ovf1 <= 1'b0;
    end else begin
      ovf0 <= set0 | (ovf0 & ~ovf0_clr);
      ovf1 <= set1 | (ovf1 & ~ovf1_clr);
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4
  AST_LO_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && inc0 && cnt0_lo == '1) |=> (ovf0 && cnt0_lo == '0)); // R5
  AST_HI_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && run1 && tick && cnt0_hi == '1) |=> (ovf1 && cnt0_hi == '0)); // R7
  AST_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == SPLIT) |=> (cnt1 == $past(cnt1))); // R8
  AST_T1_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && !ovf1 && !(run1 && tick && cnt0_hi == '1)) |=> !ovf1); // R9
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 || (gate0 && !gate_pin0)) |=> (cnt0_lo == $past(cnt0_lo))); // R3
endmodule

// File: tb/tb_split_timer_pair.sv
module tb_split_timer_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_sel = 0, event_pin = 0, gate_pin0 = 0, gate_pin1 = 0;
  logic [1:0] mode0 = 2'b00, mode1 = 2'b00;
  logic cnt_sel0 = 0, gate0 = 0, run0 = 0, gate1 = 0, run1 = 0;
  logic ovf0_clr = 0, ovf1_clr = 0;
  logic [7:0] cnt0_lo, cnt0_hi;
  logic [15:0] cnt1;
  logic ovf0, ovf1;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";
  int m_pc = 0, m_e1 = 0, m_e2 = 0, m_lo = 0, m_hi = 0, m_t1 = 0, m_f0 = 0, m_f1 = 0;

  always #10 clk = ~clk;

  split_timer_pair dut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .event_pin(event_pin),
    .gate_pin0(gate_pin0), .gate_pin1(gate_pin1), .mode0(mode0), .mode1(mode1),
    .cnt_sel0(cnt_sel0), .gate0(gate0), .run0(run0), .gate1(gate1), .run1(run1),
    .ovf0_clr(ovf0_clr), .ovf1_clr(ovf1_clr), .cnt0_lo(cnt0_lo), .cnt0_hi(cnt0_hi),
    .cnt1(cnt1), .ovf0(ovf0), .ovf1(ovf1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_e1 = 0; m_e2 = 0; m_lo = 0; m_hi = 0; m_t1 = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      int lim, tk, fl, inc, s0, s1, sp, v;
      lim = fast_sel ? 3 : 11;
      tk = (m_pc >= lim);
      fl = (m_e2 == 1 && m_e1 == 0);
      sp = (mode0 == 2'b11);
      inc = run0 && (!gate0 || gate_pin0) && (cnt_sel0 ? fl : tk);
      s0 = 0; s1 = 0;
      if (sp) begin
        if (inc) begin m_lo = (m_lo + 1) % 256; if (m_lo == 0) s0 = 1; end
        if (run1 && tk) begin m_hi = (m_hi + 1) % 256; if (m_hi == 0) s1 = 1; end
      end else if (inc) begin
        v = m_hi * 256 + m_lo + 1;
        if (v == 65536) begin v = 0; s0 = 1; end
        m_hi = v / 256; m_lo = v % 256;
      end
      if (mode1 != 2'b11 && (sp || run1) && (!gate1 || gate_pin1) && tk) begin
        m_t1 = (m_t1 + 1) % 65536;
        if (m_t1 == 0 && !sp) s1 = 1;
      end
      m_f0 = s0 || (m_f0 && !ovf0_clr);
      m_f1 = s1 || (m_f1 && !ovf1_clr);
      m_pc = tk ? 0 : m_pc + 1;
      m_e2 = m_e1; m_e1 = event_pin;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cnt0_lo == m_lo, {phase, " cnt0_lo"}, cnt0_lo, m_lo);
      chk(cnt0_hi == m_hi, {phase, " cnt0_hi"}, cnt0_hi, m_hi);
      chk(cnt1 == m_t1, {phase, " cnt1"}, cnt1, m_t1);
      chk(ovf0 == m_f0, {phase, " ovf0"}, ovf0, m_f0);
      chk(ovf1 == m_f1, {phase, " ovf1"}, ovf1, m_f1);
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_event(input int n);
    for (int i = 0; i < n; i++) begin
      event_pin = 1; wait_n(2);
      event_pin = 0; wait_n(2);
    end
  endtask

  initial begin
    int a;
    wait_n(3);
    chk(cnt0_lo == 0 && cnt0_hi == 0 && cnt1 == 0 && !ovf0 && !ovf1, "R1 reset", cnt0_lo + cnt1, 0);
    rst_n = 1;
    wait_n(1);

    phase = "R10"; fast_sel = 1; run0 = 1; mode1 = 2'b11;
    wait_n(1100);
    chk(cnt0_hi == 1, "R10 carry into high byte", cnt0_hi, 1);
    chk(ovf0 == 0, "R10 no flag at low wrap", ovf0, 0);

    phase = "R2"; mode0 = 2'b11; fast_sel = 0; wait_n(1);
    a = cnt0_lo; wait_n(48);
    chk(((cnt0_lo - a + 256) % 256) == 4, "R2 divide by 12", (cnt0_lo - a + 256) % 256, 4);
    fast_sel = 1; wait_n(1);
    a = cnt0_lo; wait_n(48);
    chk(((cnt0_lo - a + 256) % 256) == 12, "R2 divide by 4", (cnt0_lo - a + 256) % 256, 12);

    phase = "R3"; gate0 = 1; gate_pin0 = 0; wait_n(1);
    a = cnt0_lo; wait_n(50);
    chk(cnt0_lo == a, "R3 gate closed holds", cnt0_lo, a);
    gate_pin0 = 1; wait_n(48);
    chk(((cnt0_lo - a + 256) % 256) >= 11, "R3 gate open counts", cnt0_lo, a + 12);
    gate0 = 0; run0 = 0; wait_n(1);
    a = cnt0_lo; wait_n(30);
    chk(cnt0_lo == a, "R3 run off holds", cnt0_lo, a);

    phase = "R4"; run0 = 1; cnt_sel0 = 1; wait_n(4);
    a = cnt0_lo;
    pulse_event(5); wait_n(4);
    chk(((cnt0_lo - a + 256) % 256) == 5, "R4 one count per falling edge", (cnt0_lo - a + 256) % 256, 5);

    phase = "R5"; cnt_sel0 = 0; ovf0_clr = 1; wait_n(1); ovf0_clr = 0;
    wait_n(1100);
    chk(ovf0 == 1, "R5 low byte wrap sets ovf0", ovf0, 1);
    phase = "R11"; run0 = 0; wait_n(2);
    ovf0_clr = 1; wait_n(1); ovf0_clr = 0;
    chk(ovf0 == 0, "R11 clear ovf0", ovf0, 0);

    phase = "R6"; run1 = 1; gate0 = 1; gate_pin0 = 0; wait_n(1);
    a = cnt0_hi; wait_n(48);
    chk(((cnt0_hi - a + 256) % 256) == 12, "R6 high byte ignores run0/gate", (cnt0_hi - a + 256) % 256, 12);

    phase = "R7"; ovf1_clr = 1; wait_n(1); ovf1_clr = 0;
    wait_n(1100);
    chk(ovf1 == 1, "R7 high wrap sets ovf1", ovf1, 1);
    chk(ovf0 == 0, "R7 ovf0 untouched", ovf0, 0);

    phase = "R8"; run1 = 0; ovf1_clr = 1; wait_n(1); ovf1_clr = 0;
    a = cnt1; wait_n(40);
    chk(cnt1 == a, "R8 frozen in split", cnt1, a);

    phase = "R9"; mode1 = 2'b00; wait_n(1);
    a = cnt1; wait_n(48);
    chk(((cnt1 - a + 65536) % 65536) == 12, "R9 counts without run1", (cnt1 - a + 65536) % 65536, 12);
    chk(ovf1 == 0, "R9 no flag from second timer", ovf1, 0);
    mode1 = 2'b11; wait_n(1); a = cnt1; wait_n(20);
    chk(cnt1 == a, "R8 stopped by re-entering split", cnt1, a);

    phase = "R11 mixed";
    run0 = 1; run1 = 1; gate0 = 0;
    for (int i = 0; i < 6000; i++) begin
      ovf0_clr = ($urandom % 97) == 0;
      ovf1_clr = ($urandom % 89) == 0;
      event_pin = $urandom % 2;
      cnt_sel0 = (i / 1500) % 2;
      if (i % 700 == 0) mode1 = (mode1 == 2'b11) ? 2'b00 : 2'b11;
      if (i == 3000) begin mode0 = 2'b01; gate1 = 1; end
      gate_pin1 = $urandom % 2;
      wait_n(1);
    end
    ovf0_clr = 0; ovf1_clr = 0;
    wait_n(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule